// File: doc/BRIEF.md
# Video Extent Measurement Unit

This block finds where active picture content sits relative to the horizontal and vertical sync references. A controller uses the results to centre and size the raster. All counting runs on the pixel clock. Horizontal distances are counted in pixel clocks from the leading edge of horizontal sync. Vertical positions are counted in horizontal leading edges from the leading edge of vertical sync. A pixel counts as active video when any of the three colour-present inputs is at its active level.

A measurement is a single shot. When the enable bit rises, the results are preset and the unit arms. The frame that opens at the next vertical leading edge is measured. The following vertical leading edge closes it and raises the done flag. The results hold their values until the enable bit rises again. They are read one byte at a time through a combinational index port. Each value is split into a high byte and a low byte.

Top module: `vid_extent_meter`

## Requirements
- R1: After reset, done_o is 0 and the results read as the preset values: start 1023, end 0, first line 2047, last line 0, total 0, overflow 0.
- R2: A 0-to-1 transition of meas_en_i lowers done_o and presets all results. The next vertical leading edge opens the measured frame. The vertical leading edge after that closes it and raises done_o.
- R3: The horizontal position of a pixel is the number of pixel clocks since the latest horizontal leading edge. A pixel on that edge is at position 0. Across the frame, the start result is the smallest position of any active pixel and the end result is the largest.
- R4: The line index is the number of horizontal leading edges since the vertical leading edge. A horizontal edge that coincides with the vertical edge does not count. The first and last line results are the smallest and largest line indices that hold active video.
- R5: The total result counts the horizontal leading edges after the opening vertical edge, up to and including one that coincides with the closing vertical edge. It saturates at 2047. Any increment attempted at 2047 sets the sticky overflow flag.
- R6: Each of the five inputs (horizontal sync, vertical sync and the three video bits) has its own polarity bit. 1 means active-high and 0 means active-low. A sync leading edge is the transition into the active level.
- R7: Active video on any one colour input alone is enough to count a pixel.
- R8: The byte map, by read index, is as follows. Bytes 0 and 1 hold the start value: bits 9:8 in byte 0, bits 7:0 in byte 1. Bytes 2 and 3 hold the end value in the same split. Bytes 4 and 5 hold the first line: bits 10:8 in byte 4, bits 7:0 in byte 5. Bytes 6 and 7 hold the last line in the same split. Bytes 8 and 9 hold the total in the same split. Byte 8 also carries the overflow flag in bit 3. All unused bits read 0.
- R9: Video outside the measured frame has no effect on the results. This covers video while armed before the opening edge and video after done.
- R10: The pixel position saturates at 1023 instead of wrapping.
- R11: Read indices 10 to 15 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, raw level |
| vsync_i | input | 1 | Vertical sync, raw level |
| vid_i | input | 3 | Colour-present inputs {b,g,r} |
| hs_pol_i | input | 1 | Horizontal sync active level |
| vs_pol_i | input | 1 | Vertical sync active level |
| vid_pol_i | input | 3 | Active level per colour input |
| meas_en_i | input | 1 | Measurement enable; a rising transition arms a measurement |
| rd_idx_i | input | 4 | Result byte index |
| rd_data_o | output | 8 | Selected result byte |
| done_o | output | 1 | Measurement complete |

## Verification
The embedded assertions check these properties on every cycle:
- sync leading-edge pulses last a single cycle;
- the pixel and line counters hold at their ceilings;
- the overflow flag is sticky;
- the minimum start never rises during a frame;
- arming presets the state;
- the results are frozen while done;
- a completed frame has start not above end and first line not above last line whenever video was seen.

Only the bench scenarios can show that the numbers themselves are right. Those scenarios cover:
- exact pixel and line positions;
- the frame boundaries and the single-shot window;
- rejection of video before the opening edge;
- each polarity setting;
- the split-byte packing with the overflow bit;
- saturation on very long lines and very tall frames.

// File: rtl/vem_pkg.sv
package vem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_RUN,
    ST_DONE
  } vem_state_e;

  localparam int unsigned NUM_BYTES = 10;
endpackage

// File: rtl/vem_sync.sv
// Two-flop synchronizer with per-bit polarity normalisation (1 = active).
module vem_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  assign act_o = ~(s2_q ^ pol_i);
endmodule

// File: rtl/vem_lead.sv
// Leading-edge detector on normalised levels.
module vem_lead #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] act_i,
  output logic [W-1:0] lead_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= act_i;
  end

  assign lead_o = act_i & ~prev_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R6
    lead_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lead_o[i] |=> !lead_o[i]);
  end
endmodule

// File: rtl/vem_horiz.sv
// Pixel position counter and per-frame min start / max end.
module vem_horiz #(
  parameter int unsigned PIX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_lead_i,
  input  logic             vid_i,
  input  logic             meas_i,
  input  logic             clear_i,
  output logic [PIX_W-1:0] start_o,
  output logic [PIX_W-1:0] end_o
);
  localparam logic [PIX_W-1:0] PIX_MAX = '1;
  localparam logic [PIX_W-1:0] PIX_ONE = PIX_W'(1);

  logic [PIX_W-1:0] pix_q, pos;
  logic [PIX_W-1:0] start_q, end_q;

  always_comb begin
    if (hs_lead_i)             pos = '0;
    else if (pix_q == PIX_MAX) pos = PIX_MAX;
    else                       pos = pix_q + PIX_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_q <= '0;
    else         pix_q <= pos;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= PIX_MAX;
      end_q   <= '0;
    end else if (clear_i) begin
      start_q <= PIX_MAX;
      end_q   <= '0;
    end else if (meas_i && vid_i) begin
      if (pos < start_q) start_q <= pos;
      if (pos > end_q)   end_q   <= pos;
    end
  end

  assign start_o = start_q;
  assign end_o   = end_q;

  // R10
  pix_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_q == PIX_MAX && !hs_lead_i) |=> pix_q == PIX_MAX);
endmodule

// File: rtl/vem_vert.sv
// Line index counter, first/last active line, total lines and overflow.
module vem_vert #(
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_lead_i,
  input  logic              vs_lead_i,
  input  logic              vid_i,
  input  logic              meas_i,
  input  logic              close_i,
  input  logic              clear_i,
  output logic [LINE_W-1:0] first_o,
  output logic [LINE_W-1:0] last_o,
  output logic [LINE_W-1:0] total_o,
  output logic              ovf_o
);
  localparam logic [LINE_W-1:0] LN_MAX = '1;
  localparam logic [LINE_W-1:0] LN_ONE = LINE_W'(1);

  logic [LINE_W-1:0] ln_q, ln_inc, ln_pos;
  logic [LINE_W-1:0] first_q, last_q, total_q;
  logic              ovf_q, inc_at_max;

  assign ln_inc = (ln_q == LN_MAX) ? LN_MAX : ln_q + LN_ONE;

  always_comb begin
    if (vs_lead_i)      ln_pos = '0;
    else if (hs_lead_i) ln_pos = ln_inc;
    else                ln_pos = ln_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ln_q <= '0;
    else         ln_q <= ln_pos;
  end

  assign inc_at_max = hs_lead_i && (ln_q == LN_MAX) &&
                      (close_i || (meas_i && !vs_lead_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= LN_MAX;
      last_q  <= '0;
      total_q <= '0;
      ovf_q   <= 1'b0;
    end else if (clear_i) begin
      first_q <= LN_MAX;
      last_q  <= '0;
      total_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (meas_i && vid_i) begin
        if (ln_pos < first_q) first_q <= ln_pos;
        if (ln_pos > last_q)  last_q  <= ln_pos;
      end
      if (close_i) total_q <= hs_lead_i ? ln_inc : ln_q;
      if (inc_at_max) ovf_q <= 1'b1;
    end
  end

  assign first_o = first_q;
  assign last_o  = last_q;
  assign total_o = total_q;
  assign ovf_o   = ovf_q;

  // R5
  ln_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_lead_i && !vs_lead_i && ln_q == LN_MAX) |=> ln_q == LN_MAX);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clear_i) |=> ovf_q);
endmodule

// File: rtl/vid_extent_meter.sv
module vid_extent_meter
  import vem_pkg::*;
#(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned LINE_W = 11,
  parameter int unsigned IDX_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic [2:0]       vid_i,
  input  logic             hs_pol_i,
  input  logic             vs_pol_i,
  input  logic [2:0]       vid_pol_i,
  input  logic             meas_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic             done_o
);
  localparam logic [PIX_W-1:0]  PIX_MAX = '1;
  localparam logic [LINE_W-1:0] LN_MAX  = '1;
  localparam int unsigned RES_W = 2 * PIX_W + 3 * LINE_W + 1;

  logic [4:0] act;
  logic [1:0] lead;
  logic       hs_lead, vs_lead, vid_any;
  logic       en_q, arm, meas, close;
  vem_state_e state_q, state_d;

  logic [PIX_W-1:0]  hstart, hend;
  logic [LINE_W-1:0] vfirst, vlast, total;
  logic              ovf;
  logic [RES_W-1:0]  res;

  vem_sync #(.W(5)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({vsync_i, hsync_i, vid_i}),
    .pol_i  ({vs_pol_i, hs_pol_i, vid_pol_i}),
    .act_o  (act)
  );

  vem_lead #(.W(2)) u_lead (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act[4:3]),
    .lead_o (lead)
  );

  assign hs_lead = lead[0];
  assign vs_lead = lead[1];
  assign vid_any = |act[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= meas_en_i;
  end
  assign arm = meas_en_i & ~en_q;

  always_comb begin
    state_d = state_q;
    if (arm) state_d = ST_ARMED;
    else begin
      case (state_q)
        ST_ARMED: if (vs_lead) state_d = ST_RUN;
        ST_RUN:   if (vs_lead) state_d = ST_DONE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign meas  = (state_q == ST_ARMED && vs_lead) || (state_q == ST_RUN && !vs_lead);
  assign close = (state_q == ST_RUN) && vs_lead;
  assign done_o = (state_q == ST_DONE);

  vem_horiz #(.PIX_W(PIX_W)) u_horiz (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hs_lead_i (hs_lead),
    .vid_i     (vid_any),
    .meas_i    (meas),
    .clear_i   (arm),
    .start_o   (hstart),
    .end_o     (hend)
  );

  vem_vert #(.LINE_W(LINE_W)) u_vert (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hs_lead_i (hs_lead),
    .vs_lead_i (vs_lead),
    .vid_i     (vid_any),
    .meas_i    (meas),
    .close_i   (close),
    .clear_i   (arm),
    .first_o   (vfirst),
    .last_o    (vlast),
    .total_o   (total),
    .ovf_o     (ovf)
  );

  logic [15:0] hs16, he16, vf16, vl16, tt16;
  assign hs16 = 16'(hstart);
  assign he16 = 16'(hend);
  assign vf16 = 16'(vfirst);
  assign vl16 = 16'(vlast);
  assign tt16 = 16'(total);

  always_comb begin
    case (rd_idx_i)
      IDX_W'(0): rd_data_o = hs16[15:8];
      IDX_W'(1): rd_data_o = hs16[7:0];
      IDX_W'(2): rd_data_o = he16[15:8];
      IDX_W'(3): rd_data_o = he16[7:0];
      IDX_W'(4): rd_data_o = vf16[15:8];
      IDX_W'(5): rd_data_o = vf16[7:0];
      IDX_W'(6): rd_data_o = vl16[15:8];
      IDX_W'(7): rd_data_o = vl16[7:0];
      IDX_W'(8): rd_data_o = {tt16[15:12], tt16[11] | ovf, tt16[10:8]};
      IDX_W'(9): rd_data_o = tt16[7:0];
      default:   rd_data_o = 8'h00;
    endcase
  end

  assign res = {hstart, hend, vfirst, vlast, total, ovf};

  // R2
  arm_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> (state_q == ST_ARMED) && !done_o && hend == '0 && vlast == '0 && !ovf);
  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !arm) |=> $stable(res));
  // R3
  start_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !arm) |=> hstart <= $past(hstart));
  // R4
  vorder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && vfirst != LN_MAX) |-> vfirst <= vlast);
  // R3
  horder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hend != '0) |-> hstart <= hend || hstart == PIX_MAX);
  // R5
  ovf_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovf) |-> total == LN_MAX);
endmodule

// File: tb/sim_vid_extent_meter.sv
module sim_vid_extent_meter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync, vsync;
  logic [2:0] vid;
  logic       hs_pol = 1'b1, vs_pol = 1'b1;
  logic [2:0] vid_pol = 3'b111;
  logic       meas_en = 1'b0;
  logic [3:0] rd_idx = 4'd0;
  logic [7:0] rd_data;
  logic       done;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vid_extent_meter u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .hsync_i   (hsync),
    .vsync_i   (vsync),
    .vid_i     (vid),
    .hs_pol_i  (hs_pol),
    .vs_pol_i  (vs_pol),
    .vid_pol_i (vid_pol),
    .meas_en_i (meas_en),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .done_o    (done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input bit h, input bit v, input bit [2:0] col);
    hsync = h ? hs_pol : ~hs_pol;
    vsync = v ? vs_pol : ~vs_pol;
    vid   = ~(col ^ vid_pol);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      put(1'b0, 1'b0, 3'b000);
    end
  endtask

  task automatic line(input int len, input int hw, input bit vact,
                      input int vst, input int ven, input bit [2:0] col);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      put(c < hw, vact, (c >= vst && c <= ven) ? col : 3'b000);
    end
  endtask

  task automatic rd(input int idx, output logic [7:0] v);
    @(negedge clk);
    rd_idx = 4'(idx);
    #1 v = rd_data;
  endtask

  // R8 byte map
  task automatic check_bytes(input string tag, input int hs, input int he,
                             input int vf, input int vl, input int tt, input bit ov);
    logic [7:0] v;
    int exp[10];
    exp[0] = (hs >> 8) & 8'h03; exp[1] = hs & 8'hff;
    exp[2] = (he >> 8) & 8'h03; exp[3] = he & 8'hff;
    exp[4] = (vf >> 8) & 8'h07; exp[5] = vf & 8'hff;
    exp[6] = (vl >> 8) & 8'h07; exp[7] = vl & 8'hff;
    exp[8] = ((tt >> 8) & 8'h07) | (ov ? 8'h08 : 8'h00); exp[9] = tt & 8'hff;
    for (int i = 0; i < 10; i++) begin
      rd(i, v);
      chk($sformatf("%s R8 byte%0d", tag, i), v, exp[i]);
    end
  endtask

  task automatic arm();
    @(negedge clk); meas_en = 1'b0;
    idle(3);
    @(negedge clk); meas_en = 1'b1;
    put(1'b0, 1'b0, 3'b000);
    idle(3);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 done after reset", done, 0);
    check_bytes("R1 reset", 1023, 0, 2047, 0, 0, 1'b0);
    for (int i = 10; i < 16; i++) begin
      rd(i, v);
      chk($sformatf("R11 idx%0d", i), v, 0);
    end
  endtask

  task automatic t_basic();
    int st[8] = '{0, 0, 12, 10, 11, 15, 0, 0};
    int en[8] = '{-1, -1, 30, 33, 31, 29, -1, -1};
    bit [2:0] cl[8] = '{3'b000, 3'b000, 3'b001, 3'b010, 3'b100, 3'b011, 3'b000, 3'b000};
    arm();
    chk("R2 done low when armed", done, 0);
    // R9: video while armed, before the opening vertical edge
    line(40, 4, 1'b0, 2, 20, 3'b001);
    line(40, 4, 1'b0, 2, 20, 3'b001);
    for (int k = 0; k < 8; k++) line(40, 4, k < 2, st[k], en[k], cl[k]);
    chk("R2 done low before close", done, 0);
    line(40, 4, 1'b1, 1, 0, 3'b000);
    line(40, 4, 1'b0, 1, 0, 3'b000);
    chk("R2 done after close", done, 1);
    // R3 R4 R5 R7 R9
    check_bytes("R3 basic", 10, 33, 2, 5, 8, 1'b0);
  endtask

  task automatic t_hold();
    // R9: video after done has no effect
    for (int k = 0; k < 4; k++) line(40, 4, k == 0, 1, 38, 3'b111);
    line(40, 4, 1'b1, 1, 38, 3'b111);
    chk("R9 done held", done, 1);
    check_bytes("R9 hold", 10, 33, 2, 5, 8, 1'b0);
  endtask

  task automatic t_rearm();
    arm();
    chk("R2 rearm done low", done, 0);
    check_bytes("R2 rearm preset", 1023, 0, 2047, 0, 0, 1'b0);
  endtask

  task automatic t_polarity();
    @(negedge clk); meas_en = 1'b0;
    hs_pol = 1'b0; vs_pol = 1'b0; vid_pol = 3'b101;
    put(1'b0, 1'b0, 3'b000);
    idle(6);
    arm();
    for (int k = 0; k < 6; k++) begin
      if (k == 1)      line(30, 3, 1'b0, 7, 20, 3'b010);
      else if (k == 2) line(30, 3, 1'b0, 9, 18, 3'b010);
      else             line(30, 3, k == 0, 1, 0, 3'b000);
    end
    line(30, 3, 1'b1, 1, 0, 3'b000);
    line(30, 3, 1'b0, 1, 0, 3'b000);
    chk("R6 done with inverted polarity", done, 1);
    check_bytes("R6 polarity", 7, 20, 1, 2, 6, 1'b0);
    @(negedge clk);
    hs_pol = 1'b1; vs_pol = 1'b1; vid_pol = 3'b111;
    put(1'b0, 1'b0, 3'b000);
    idle(6);
  endtask

  task automatic t_overflow();
    arm();
    for (int k = 0; k < 2050; k++) begin
      if (k == 3) line(6, 2, 1'b0, 3, 4, 3'b100);
      else        line(6, 2, k == 0, 1, 0, 3'b000);
    end
    line(6, 2, 1'b1, 1, 0, 3'b000);
    idle(6);
    chk("R5 done after tall frame", done, 1);
    check_bytes("R5 overflow", 3, 4, 3, 3, 2047, 1'b1);
  endtask

  task automatic t_pixsat();
    arm();
    line(1100, 4, 1'b1, 1, 0, 3'b000);
    line(1100, 4, 1'b0, 1000, 1060, 3'b010);
    line(1100, 4, 1'b0, 1, 0, 3'b000);
    line(20, 4, 1'b1, 1, 0, 3'b000);
    idle(6);
    chk("R10 done", done, 1);
    check_bytes("R10 saturation", 1000, 1023, 1, 1, 3, 1'b0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    put(1'b0, 1'b0, 3'b000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_basic();
    t_hold();
    t_rearm();
    t_polarity();
    t_overflow();
    t_pixsat();
    finish_run();
  end
endmodule